// File: doc/BRIEF.md
# Sprite Memory DMA Controller

This block sequences a 256-byte copy from the CPU address space into the video chip's sprite data port. It is a cycle-level synchronous model. The controller owns no data path. It produces the source address, a read strobe that fetches one byte into an external holding buffer, a write strobe that pushes that byte to the video port, and a counter-advance strobe. It also drives the CPU ready line that stalls the processor while the copy runs.

A CPU write to the trigger register arms the controller and captures the page (high address byte) to copy from. Each transfer takes its low address byte from zero. Once armed, the controller waits for a CPU read cycle, because a halt request is only honoured then. It then waits for the next alternate bus phase before the transfer begins. After that, every bus-phase beat alternates between a fetch and a store. A second DMA engine can hold a suspend input high. Suspension blanks the strobes and freezes the address, but the fetch/store alternation keeps running. The CPU ready output is the AND of this controller's own ready state and the other engine's ready flag.

Top module: `sdma_ctrl`

## Requirements
- R1: After reset, no strobe is active, the low address byte is zero, and `cpu_rdy` equals `peer_rdy`.
- R2: `trig_wr` arms the controller only in a cycle with `phi1` = 0. A write with `phi1` = 1 is ignored: no strobe follows and `cpu_rdy` stays high.
- R3: An armed controller starts only after a cycle with `cpu_rd` = 1 and `phi1` = 0. While the CPU only writes, `cpu_rdy` stays high and no strobe appears.
- R4: The transfer state, and with it the CPU ready state, changes only at a clock edge where `bus_ce` = 1.
- R5: During a transfer there is exactly one strobe on each unsuspended `bus_ce` beat. The first strobe is a fetch (`rd_stb`) and fetch and store (`wr_stb`) then alternate, 256 of each per transfer. No strobe appears outside `bus_ce` beats.
- R6: Each address from {page, 0} to {page, 255} is fetched once and then stored once at that same address. `inc_stb` accompanies each store.
- R7: After the 256th store, the transfer ends at the next `bus_ce` edge and `cpu_rdy` returns to `peer_rdy`.
- R8: While `susp_in` = 1, no strobe is issued and the low address byte is frozen, but the fetch/store alternation keeps stepping. After an even number of suspended beats, the sequence resumes with no skipped or repeated address or direction.
- R9: `cpu_rdy` is low for the whole transfer whatever `peer_rdy` is. When idle, `cpu_rdy` equals `peer_rdy`.
- R10: The arming is consumed when a transfer starts. After a transfer ends, further CPU read cycles start nothing until a new trigger write.
- R11: A new transfer uses the page written last and begins at low address byte zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one CPU half-cycle per period |
| rst | input | 1 | Synchronous reset, active high |
| trig_wr | input | 1 | CPU write strobe to the trigger register |
| trig_data | input | HI_W | Page byte written with the trigger |
| cpu_rd | input | 1 | CPU read/write line, 1 = read |
| phi1 | input | 1 | 1 during the first half of a CPU cycle |
| bus_ce | input | 1 | Alternate bus-phase beat enable |
| susp_in | input | 1 | Suspend request from the other DMA engine |
| peer_rdy | input | 1 | Ready flag of the other DMA engine |
| src_addr | output | HI_W+CNT_W | Source address {page, low counter} |
| rd_stb | output | 1 | Fetch a byte at `src_addr` into the buffer |
| wr_stb | output | 1 | Store the buffered byte to the video port |
| inc_stb | output | 1 | Low counter advances at this edge |
| cpu_rdy | output | 1 | Combined CPU ready line |

## Verification
The bench builds the block with its default parameters: an 8-bit low counter, an 8-bit page and the combinational ready path. At these values the full 512-strobe transfer and the counter wrap that ends it are in reach. Two suspension windows of two beats each are injected, one after a store and one between a fetch and its store. Together they show that the direction resumes in step whichever beat a suspension starts on. Random CPU read/write patterns and random `peer_rdy` values vary the start latency and test the ready combining.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
   typedef enum logic {
      DIR_FETCH = 1'b0,
      DIR_STORE = 1'b1
   } sdma_dir_e;
endpackage

// File: rtl/sdma_trigger.sv
module sdma_trigger #(
   parameter int HI_W = 8
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            trig_wr,
   input  logic [HI_W-1:0] trig_data,
   input  logic            cpu_rd,
   input  logic            phi1,
   input  logic            busy,
   input  logic            ovf,
   output logic            en,
   output logic [HI_W-1:0] page
);
   logic pend;
   logic wr_ok;
   logic start;

   assign wr_ok = trig_wr & ~phi1;
   assign start = pend & cpu_rd & ~phi1;

   // arming flag: consumed as soon as the transfer runs
   always_ff @(posedge clk) begin
      if (rst)        pend <= 1'b0;
      else if (busy)  pend <= 1'b0;
      else if (wr_ok) pend <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst)                page <= '0;
      else if (wr_ok && !busy) page <= trig_data;
   end

   // enable flag: set by the start event, cleared by counter wrap
   always_ff @(posedge clk) begin
      if (rst)        en <= 1'b0;
      else if (ovf)   en <= 1'b0;
      else if (start) en <= 1'b1;
   end

   // R3
   start_on_read_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(en) |-> $past(cpu_rd && !phi1));

   // R2
   phase_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
      (trig_wr && phi1 && !pend && !busy) |=> !pend);
endmodule

// File: rtl/sdma_sequencer.sv
module sdma_sequencer
   import sdma_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      bus_ce,
   input  logic      en,
   input  logic      susp,
   output logic      busy,
   output sdma_dir_e dir,
   output logic      rd_stb,
   output logic      wr_stb
);
   logic live;

   // phase-aligned run latch: follows the enable only on bus beats
   always_ff @(posedge clk) begin
      if (rst)         busy <= 1'b0;
      else if (bus_ce) busy <= en;
   end

   // direction keeps stepping through suspension
   always_ff @(posedge clk) begin
      if (rst || !busy)  dir <= DIR_FETCH;
      else if (bus_ce)   dir <= (dir == DIR_FETCH) ? DIR_STORE : DIR_FETCH;
   end

   assign live   = busy & en & bus_ce & ~susp;
   assign rd_stb = live & (dir == DIR_FETCH);
   assign wr_stb = live & (dir == DIR_STORE);

   // R4
   run_on_phase_chk: assert property (@(posedge clk) disable iff (rst)
      !bus_ce |=> $stable(busy));

   // R5
   dir_alternates_chk: assert property (@(posedge clk) disable iff (rst)
      (busy && en && bus_ce) |=> (dir != $past(dir)));
endmodule

// File: rtl/sdma_addr.sv
module sdma_addr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             busy,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt,
   output logic             ovf
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk) begin
      if (rst || !busy) cnt <= '0;
      else if (inc)     cnt <= cnt + 1'b1;
   end

   assign ovf = inc & (cnt == CNT_MAX);

   // R11
   fresh_low_byte_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> (cnt == '0));

   // R7
   wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
      ovf |=> (cnt == '0));
endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
   import sdma_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int HI_W    = 8,
   parameter bit REG_RDY = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 trig_wr,
   input  logic [HI_W-1:0]      trig_data,
   input  logic                 cpu_rd,
   input  logic                 phi1,
   input  logic                 bus_ce,
   input  logic                 susp_in,
   input  logic                 peer_rdy,
   output logic [HI_W+CNT_W-1:0] src_addr,
   output logic                 rd_stb,
   output logic                 wr_stb,
   output logic                 inc_stb,
   output logic                 cpu_rdy
);
   localparam int ADDR_W = HI_W + CNT_W;

   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("sdma_ctrl: CNT_W out of range");
   end
   if (HI_W < 1 || ADDR_W > 32) begin : g_bad_hi
      $error("sdma_ctrl: HI_W out of range");
   end

   logic             en;
   logic             busy;
   logic             ovf;
   logic [HI_W-1:0]  page;
   logic [CNT_W-1:0] cnt;
   sdma_dir_e        dir;
   logic             own_rdy;

   sdma_trigger #(.HI_W(HI_W)) u_trig (
      .clk(clk), .rst(rst), .trig_wr(trig_wr), .trig_data(trig_data),
      .cpu_rd(cpu_rd), .phi1(phi1), .busy(busy), .ovf(ovf),
      .en(en), .page(page)
   );

   sdma_sequencer u_seq (
      .clk(clk), .rst(rst), .bus_ce(bus_ce), .en(en), .susp(susp_in),
      .busy(busy), .dir(dir), .rd_stb(rd_stb), .wr_stb(wr_stb)
   );

   sdma_addr #(.CNT_W(CNT_W)) u_addr (
      .clk(clk), .rst(rst), .busy(busy), .inc(wr_stb),
      .cnt(cnt), .ovf(ovf)
   );

   assign inc_stb  = wr_stb;
   assign src_addr = {page, cnt};
   assign own_rdy  = ~busy;

   if (REG_RDY) begin : g_rdy_reg
      logic rdy_q;
      always_ff @(posedge clk) begin
         if (rst) rdy_q <= 1'b0;
         else     rdy_q <= own_rdy & peer_rdy;
      end
      assign cpu_rdy = rdy_q;

      // R9
      halt_during_xfer_chk: assert property (@(posedge clk) disable iff (rst)
         busy |=> !cpu_rdy);
   end else begin : g_rdy_comb
      assign cpu_rdy = own_rdy & peer_rdy;

      // R9
      halt_during_xfer_chk: assert property (@(posedge clk) disable iff (rst)
         (rd_stb || wr_stb) |-> !cpu_rdy);
   end

   // R8
   suspend_freeze_chk: assert property (@(posedge clk) disable iff (rst)
      (susp_in && busy) |=> $stable(src_addr[CNT_W-1:0]));

   // R5
   one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
      !(rd_stb && wr_stb));
endmodule

// File: tb/sdma_ctrl_test.sv
module sdma_ctrl_test;
   localparam int CLK_P = 10;
   localparam int CNT_W = 8;
   localparam int HI_W  = 8;
   localparam int NB    = 1 << CNT_W;

   logic                  clk = 1'b0;
   logic                  rst, trig_wr, cpu_rd, phi1, bus_ce, susp_in, peer_rdy;
   logic [HI_W-1:0]       trig_data;
   logic [HI_W+CNT_W-1:0] src_addr;
   logic                  rd_stb, wr_stb, inc_stb, cpu_rdy;

   sdma_ctrl #(.CNT_W(CNT_W), .HI_W(HI_W), .REG_RDY(1'b0)) uut (
      .clk(clk), .rst(rst), .trig_wr(trig_wr), .trig_data(trig_data),
      .cpu_rd(cpu_rd), .phi1(phi1), .bus_ce(bus_ce), .susp_in(susp_in),
      .peer_rdy(peer_rdy), .src_addr(src_addr), .rd_stb(rd_stb),
      .wr_stb(wr_stb), .inc_stb(inc_stb), .cpu_rdy(cpu_rdy)
   );

   always #(CLK_P/2) clk = ~clk;

   int checks = 0, errors = 0;
   int ph = 0;
   bit d_rst = 1, d_tw = 0, d_rd = 0, d_susp = 0, d_peer = 1;
   logic [HI_W-1:0] d_td = '0;
   logic [HI_W-1:0] sb_hi = '0;
   int sb_idx = 0, rd_cnt = 0, wr_cnt = 0, susp_hits = 0;
   bit sb_wr = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_addr(input logic [HI_W-1:0] hi, input int idx);
      return (int'(hi) << CNT_W) + idx;
   endfunction

   task automatic step();
      @(negedge clk);
      ph = (ph + 1) % 4;
      rst = d_rst; trig_wr = d_tw; trig_data = d_td; cpu_rd = d_rd;
      susp_in = d_susp; peer_rdy = d_peer;
      phi1 = (ph % 2 == 0);
      bus_ce = (ph == 3);
      #(CLK_P/2 - 1);
      if (!rst && (rd_stb || wr_stb)) begin
         check(bus_ce, "R5", "strobe on bus beat", int'(bus_ce), 1);
         check(!cpu_rdy, "R9", "ready low during transfer", int'(cpu_rdy), 0);
         check(!susp_in, "R8", "no strobe while suspended", int'(susp_in), 0);
         if (susp_in) susp_hits++;
         check(inc_stb == wr_stb, "R6", "increment with store", int'(inc_stb), int'(wr_stb));
         if (rd_stb) begin
            check(!sb_wr, "R5", "fetch expected", int'(sb_wr), 0);
            check(src_addr == exp_addr(sb_hi, sb_idx), "R6", "fetch address",
                  int'(src_addr), exp_addr(sb_hi, sb_idx));
            sb_wr = 1; rd_cnt++;
         end else begin
            check(sb_wr, "R5", "store expected", int'(sb_wr), 1);
            check(src_addr == exp_addr(sb_hi, sb_idx), "R6", "store address",
                  int'(src_addr), exp_addr(sb_hi, sb_idx));
            sb_wr = 0; sb_idx++; wr_cnt++;
         end
      end
   endtask

   task automatic trigger(input logic [HI_W-1:0] hi, input bit first_half);
      d_tw = 0;
      while ((((ph + 1) % 4) % 2 == 0) != first_half) step();
      d_tw = 1; d_td = hi; d_rd = 0;
      step();
      d_tw = 0;
      if (!first_half) begin
         sb_hi = hi; sb_idx = 0; sb_wr = 0; rd_cnt = 0; wr_cnt = 0;
      end
   endtask

   task automatic run_xfer(input int susp_at_a, input int susp_at_b);
      int n = 0;
      bit did_a = 0, did_b = 0;
      while (wr_cnt < NB && n < 6000) begin
         d_rd = 1'($urandom);
         d_peer = 1'($urandom);
         if (!did_a && wr_cnt == susp_at_a && !sb_wr && rd_cnt > 0) begin
            did_a = 1;
            suspend_window();
         end else if (!did_b && wr_cnt == susp_at_b && sb_wr) begin
            did_b = 1;
            suspend_window();
         end else begin
            step();
         end
         n++;
      end
      d_peer = 1;
      repeat (8) step();
      check(rd_cnt == NB, "R5", "fetch count", rd_cnt, NB);
      check(wr_cnt == NB, "R6", "store count", wr_cnt, NB);
      check(cpu_rdy == 1'b1, "R7", "ready back after end", int'(cpu_rdy), 1);
   endtask

   task automatic suspend_window();
      int r0 = rd_cnt, w0 = wr_cnt;
      d_susp = 1;
      repeat (8) step();
      d_susp = 0;
      check(rd_cnt == r0 && wr_cnt == w0, "R8", "strobes during suspension",
            rd_cnt + wr_cnt, r0 + w0);
   endtask

   task automatic idle_window(input int len, input string req);
      int r0 = rd_cnt;
      bit bad = 0;
      repeat (len) begin
         d_rd = 1'($urandom);
         d_peer = 1'($urandom);
         step();
         if (cpu_rdy !== peer_rdy) bad = 1;
      end
      d_peer = 1;
      check(rd_cnt == r0, req, "no transfer while idle", rd_cnt, r0);
      check(!bad, "R9", "idle ready follows peer", int'(bad), 0);
   endtask

   initial begin
      #(CLK_P * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
      $finish;
   end

   initial begin
      bit low_seen;
      void'($urandom(32'h5D3A));
      d_rst = 1;
      repeat (4) step();
      d_rst = 0;
      step();
      // R1
      check(!rd_stb && !wr_stb, "R1", "no strobe after reset", int'(rd_stb | wr_stb), 0);
      check(src_addr[CNT_W-1:0] == '0, "R1", "low byte zero", int'(src_addr[CNT_W-1:0]), 0);
      check(cpu_rdy == peer_rdy, "R1", "ready follows peer", int'(cpu_rdy), int'(peer_rdy));

      // R2: write in first half ignored
      trigger(8'h5A, 1'b1);
      idle_window(40, "R2");

      // R3: armed but CPU keeps writing
      trigger(8'h3C, 1'b0);
      low_seen = 0;
      d_rd = 0;
      repeat (40) begin step(); if (!cpu_rdy) low_seen = 1; end
      check(!low_seen && rd_cnt == 0, "R3", "no start without read cycle", int'(low_seen), 0);

      // R5 R6 R7 R8: full transfer with two suspension windows
      run_xfer(100, 200);
      check(susp_hits == 0, "R8", "suspended strobes", susp_hits, 0);

      // R10: arming consumed
      idle_window(60, "R10");

      // R11: new page, counter from zero
      trigger(8'hC3, 1'b0);
      run_xfer(-1, -1);
      check(src_addr[CNT_W-1:0] == '0, "R11", "low byte rest", int'(src_addr[CNT_W-1:0]), 0);
      idle_window(40, "R10");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule